// File: doc/BRIEF.md
# Masked Lock-Step Vector Element Array

This block is a small single-instruction, multiple-data engine. One sequencer owns a program store. It fetches and decodes each instruction word, then issues the decoded operation to a row of processing elements, and every element carries it out in the same cycle. Each element has a private data store, one accumulator and an ALU. An element's operand comes from its own store, at the address carried by the issued instruction. A participation mask, which the program itself writes, selects which elements act on each instruction. A ring-shaped exchange path lets every enabled element take a neighbour's accumulator in a single step.

A host fills the program store and the element data stores through a single write port while the engine is stopped. It pulses `start`, waits for `done`, and then reads the results back through the data read port. There is no host protocol beyond this word-wide write/read access.

Top module: `simd_pe_array`

## Requirements
- R1: After reset, `done` is low, the engine is idle, all accumulators and all data and program words are zero, and the mask is all ones.
- R2: `start` seen while idle or done begins a run at program address 0. Each instruction takes one fetch cycle and one execute cycle. For a program whose n-th word is the halt, `done` goes high 2n clock edges after the edge that sampled `start`, and it stays high until the next `start`.
- R3: An instruction word is 8 bits: opcode in [7:4], operand in [3:0]. LOAD (1) copies store[operand] into the accumulator. ADD (3) adds store[operand] to the accumulator and SUB (4) subtracts it, both modulo 2^16. Each element uses its own store.
- R4: STORE (2) writes each enabled element's accumulator to store[operand] of that element.
- R5: SETMASK (5) loads operand bits [3:0] into the mask, with bit i enabling element i. The new mask applies from the next instruction. A disabled element changes neither its accumulator nor its store.
- R6: ROUTE (6) makes each enabled element i take the accumulator that element (i+1) mod 4 held before the instruction, so every transfer happens at once and the ring wraps around.
- R7: HALT (7) ends the run. Opcode 0 and the unused opcodes 8 to 15 change no state.
- R8: With `host_we` high while idle or done, the word at `host_addr` is written: into element `host_pe`'s store when `host_to_data` is 1, and into the program store (low 8 bits) when it is 0. Host writes during a run are ignored. `host_rdata` always shows element `host_pe`'s store at `host_addr`, combinationally.
- R9: Every `start` sets the mask back to all ones. Accumulators keep their values from one run to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run from program address 0 |
| done | output | 1 | High once HALT has executed, until the next start |
| host_we | input | 1 | Host write strobe, honoured only when stopped |
| host_to_data | input | 1 | 1 selects an element data store, 0 the program store |
| host_pe | input | 2 | Element selected for host data write and read |
| host_addr | input | 4 | Word address for host write and read |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Selected element's data word at host_addr |

## Verification
Some behaviours are checked by assertions on every cycle. A masked-off element holds its accumulator. ROUTE takes exactly the neighbour value of the previous cycle, and STORE and ADD produce the expected memory and accumulator values one cycle later. The program counter steps once per fetch, `done` follows an executed halt, and the mask is all ones after each start. Other behaviours can only be shown by the bench's scenarios, through the cycle-by-cycle model: the end-to-end arithmetic with wraparound, the mask persisting across several instructions, host writes ignored during a run (program and data), accumulators carried over between runs, and the exact timing of `done`.

// File: rtl/simd_pkg.sv
package simd_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OP_NOP   = 4'd0,
      OP_LOAD  = 4'd1,
      OP_STORE = 4'd2,
      OP_ADD   = 4'd3,
      OP_SUB   = 4'd4,
      OP_MASK  = 4'd5,
      OP_ROUTE = 4'd6,
      OP_HALT  = 4'd7
   } opcode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_EXEC  = 2'd2,
      ST_DONE  = 2'd3
   } cu_state_e;

endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
   import simd_pkg::*;
#(
   parameter int NUM_PE     = 4,
   parameter int PMEM_DEPTH = 16,
   parameter int OPND_W     = 4,
   localparam int PMEM_AW   = $clog2(PMEM_DEPTH),
   localparam int INSTR_W   = OPC_W + OPND_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               pm_we,
   input  logic [PMEM_AW-1:0] pm_addr,
   input  logic [INSTR_W-1:0] pm_wdata,
   output logic               busy,
   output logic               done,
   output logic               bc_valid,
   output opcode_e            bc_op,
   output logic [OPND_W-1:0]  bc_operand,
   output logic [NUM_PE-1:0]  mask
);

   cu_state_e          state_q;
   logic [PMEM_AW-1:0] pc_q;
   logic [INSTR_W-1:0] ir_q;
   logic [INSTR_W-1:0] pmem_q [PMEM_DEPTH];
   logic [NUM_PE-1:0]  mask_q;
   logic               stopped;

   assign stopped    = (state_q == ST_IDLE) || (state_q == ST_DONE);
   assign busy       = !stopped;
   assign done       = (state_q == ST_DONE);
   assign bc_valid   = (state_q == ST_EXEC);
   assign bc_op      = opcode_e'(ir_q[INSTR_W-1 -: OPC_W]);
   assign bc_operand = ir_q[OPND_W-1:0];
   assign mask       = mask_q;

   // program store, host side
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < PMEM_DEPTH; k++) pmem_q[k] <= '0;
      end else if (pm_we && stopped) begin
         pmem_q[pm_addr] <= pm_wdata;
      end
   end

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pc_q    <= '0;
         ir_q    <= '0;
         mask_q  <= '1;
      end else begin
         unique case (state_q)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  state_q <= ST_FETCH;
                  pc_q    <= '0;
                  mask_q  <= '1;
               end
            end
            ST_FETCH: begin
               ir_q    <= pmem_q[pc_q];
               pc_q    <= pc_q + 1'b1;
               state_q <= ST_EXEC;
            end
            ST_EXEC: begin
               if (bc_op == OP_MASK) mask_q <= bc_operand[NUM_PE-1:0];
               state_q <= (bc_op == OP_HALT) ? ST_DONE : ST_FETCH;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FETCH) |=> (pc_q == PMEM_AW'($past(pc_q) + 1'b1)));

   p_done_after_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_valid && bc_op == OP_HALT) |=> done);

   p_done_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_valid && bc_op == OP_MASK) |=> (mask_q == $past(bc_operand[NUM_PE-1:0])));

   p_mask_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stopped && start) |=> (&mask_q));

endmodule

// File: rtl/simd_pe.sv
module simd_pe
   import simd_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int LMEM_DEPTH = 16,
   localparam int LMEM_AW   = $clog2(LMEM_DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  opcode_e            op,
   input  logic [LMEM_AW-1:0] addr,
   input  logic [DATA_W-1:0]  nbr_acc,
   input  logic               host_we,
   input  logic [LMEM_AW-1:0] host_addr,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic [DATA_W-1:0]  host_rdata,
   output logic [DATA_W-1:0]  acc_o
);

   logic [DATA_W-1:0] lmem_q [LMEM_DEPTH];
   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] acc_d;
   logic [DATA_W-1:0] opnd;

   assign opnd       = lmem_q[addr];
   assign host_rdata = lmem_q[host_addr];
   assign acc_o      = acc_q;

   always_comb begin
      unique case (op)
         OP_LOAD:  acc_d = opnd;
         OP_ADD:   acc_d = acc_q + opnd;
         OP_SUB:   acc_d = acc_q - opnd;
         OP_ROUTE: acc_d = nbr_acc;
         default:  acc_d = acc_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else if (en) acc_q <= acc_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < LMEM_DEPTH; k++) lmem_q[k] <= '0;
      end else if (host_we) begin
         lmem_q[host_addr] <= host_wdata;
      end else if (en && op == OP_STORE) begin
         lmem_q[addr] <= acc_q;
      end
   end

   p_masked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(acc_q));

   p_route_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op == OP_ROUTE) |=> (acc_q == $past(nbr_acc)));

   p_store_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op == OP_STORE && !host_we) |=> (lmem_q[$past(addr)] == $past(acc_q)));

   p_add_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op == OP_ADD) |=> (acc_q == DATA_W'($past(acc_q) + $past(opnd))));

endmodule

// File: rtl/simd_route.sv
module simd_route #(
   parameter int NUM_PE    = 4,
   parameter int DATA_W    = 16,
   parameter bit FROM_HIGH = 1'b1
) (
   input  logic [NUM_PE-1:0][DATA_W-1:0] acc_in,
   output logic [NUM_PE-1:0][DATA_W-1:0] nbr_out
);

   for (genvar i = 0; i < NUM_PE; i++) begin : g_ring
      if (FROM_HIGH) begin : g_high
         localparam int SRC = (i + 1) % NUM_PE;
         assign nbr_out[i] = acc_in[SRC];
      end else begin : g_low
         localparam int SRC = (i + NUM_PE - 1) % NUM_PE;
         assign nbr_out[i] = acc_in[SRC];
      end
   end

endmodule

// File: rtl/simd_pe_array.sv
module simd_pe_array
   import simd_pkg::*;
#(
   parameter int NUM_PE     = 4,
   parameter int DATA_W     = 16,
   parameter int LMEM_DEPTH = 16,
   parameter int PMEM_DEPTH = 16,
   parameter bit FROM_HIGH  = 1'b1,
   localparam int PE_IW     = (NUM_PE > 1) ? $clog2(NUM_PE) : 1,
   localparam int LMEM_AW   = $clog2(LMEM_DEPTH),
   localparam int PMEM_AW   = $clog2(PMEM_DEPTH),
   localparam int HOST_AW   = (LMEM_AW > PMEM_AW) ? LMEM_AW : PMEM_AW,
   localparam int OPND_W    = (LMEM_AW > NUM_PE) ? LMEM_AW : NUM_PE,
   localparam int INSTR_W   = OPC_W + OPND_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   output logic               done,
   input  logic               host_we,
   input  logic               host_to_data,
   input  logic [PE_IW-1:0]   host_pe,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic [DATA_W-1:0]  host_rdata
);

   if (NUM_PE < 2) begin : g_chk_pe
      $error("simd_pe_array: NUM_PE must be at least 2");
   end
   if (INSTR_W > DATA_W) begin : g_chk_w
      $error("simd_pe_array: instruction word wider than host data");
   end
   if ((1 << LMEM_AW) != LMEM_DEPTH || (1 << PMEM_AW) != PMEM_DEPTH) begin : g_chk_d
      $error("simd_pe_array: memory depths must be powers of two");
   end

   logic                          busy;
   logic                          bc_valid;
   opcode_e                       bc_op;
   logic [OPND_W-1:0]             bc_operand;
   logic [NUM_PE-1:0]             mask;
   logic [NUM_PE-1:0][DATA_W-1:0] acc_vec;
   logic [NUM_PE-1:0][DATA_W-1:0] nbr_vec;
   logic [NUM_PE-1:0][DATA_W-1:0] rd_vec;

   simd_ctrl #(
      .NUM_PE     (NUM_PE),
      .PMEM_DEPTH (PMEM_DEPTH),
      .OPND_W     (OPND_W)
   ) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .pm_we      (host_we && !host_to_data),
      .pm_addr    (host_addr[PMEM_AW-1:0]),
      .pm_wdata   (host_wdata[INSTR_W-1:0]),
      .busy       (busy),
      .done       (done),
      .bc_valid   (bc_valid),
      .bc_op      (bc_op),
      .bc_operand (bc_operand),
      .mask       (mask)
   );

   simd_route #(
      .NUM_PE    (NUM_PE),
      .DATA_W    (DATA_W),
      .FROM_HIGH (FROM_HIGH)
   ) route_i (
      .acc_in  (acc_vec),
      .nbr_out (nbr_vec)
   );

   for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
      logic wr_sel;
      assign wr_sel = host_we && host_to_data && !busy && (host_pe == PE_IW'(i));

      simd_pe #(
         .DATA_W     (DATA_W),
         .LMEM_DEPTH (LMEM_DEPTH)
      ) pe_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .en         (bc_valid && mask[i]),
         .op         (bc_op),
         .addr       (bc_operand[LMEM_AW-1:0]),
         .nbr_acc    (nbr_vec[i]),
         .host_we    (wr_sel),
         .host_addr  (host_addr[LMEM_AW-1:0]),
         .host_wdata (host_wdata),
         .host_rdata (rd_vec[i]),
         .acc_o      (acc_vec[i])
      );
   end

   assign host_rdata = rd_vec[host_pe];

   p_no_run_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bc_valid && bc_op != OP_STORE) |=> $stable(rd_vec));

endmodule

// File: tb/simd_pe_array_tb_top.sv
module simd_pe_array_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        done;
   logic        host_we = 1'b0;
   logic        host_to_data = 1'b0;
   logic [1:0]  host_pe = '0;
   logic [3:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   simd_pe_array dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done),
      .host_we(host_we), .host_to_data(host_to_data), .host_pe(host_pe),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   // behavioural reference model
   logic [15:0] m_mem [4][16];
   logic [7:0]  m_pm [16];
   logic [15:0] m_acc [4];
   logic [3:0]  m_mask;
   int          m_pc;
   int          m_ph;   // 0 idle, 1 fetch, 2 exec, 3 done
   logic [7:0]  m_ir;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < 4; p++) begin
            m_acc[p] = '0;
            for (int a = 0; a < 16; a++) m_mem[p][a] = '0;
         end
         for (int a = 0; a < 16; a++) m_pm[a] = '0;
         m_mask = 4'hF; m_pc = 0; m_ph = 0; m_ir = '0;
      end else begin
         case (m_ph)
            0, 3: begin
               if (host_we) begin
                  if (host_to_data) m_mem[host_pe][host_addr] = host_wdata;
                  else m_pm[host_addr] = host_wdata[7:0];
               end
               if (start) begin m_ph = 1; m_pc = 0; m_mask = 4'hF; end
            end
            1: begin m_ir = m_pm[m_pc]; m_pc = (m_pc + 1) % 16; m_ph = 2; end
            default: begin
               logic [15:0] old [4];
               int op, a;
               op = m_ir[7:4]; a = m_ir[3:0];
               for (int p = 0; p < 4; p++) old[p] = m_acc[p];
               for (int p = 0; p < 4; p++) begin
                  if (m_mask[p]) begin
                     case (op)
                        1: m_acc[p] = m_mem[p][a];
                        2: m_mem[p][a] = old[p];
                        3: m_acc[p] = old[p] + m_mem[p][a];
                        4: m_acc[p] = old[p] - m_mem[p][a];
                        6: m_acc[p] = old[(p + 1) % 4];
                        default: ;
                     endcase
                  end
               end
               if (op == 5) m_mask = a[3:0];
               m_ph = (op == 7) ? 3 : 1;
            end
         endcase
      end
   end

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
      end
   endtask

   // per-clock comparison, away from the edges
   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         check("R2", {15'd0, done}, {15'd0, (m_ph == 3)});
         check(cur_req, host_rdata, m_mem[host_pe][host_addr]);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic logic [15:0] ins(input int op, input int opnd);
      return {8'h00, op[3:0], opnd[3:0]};
   endfunction

   task automatic host_write(input bit to_data, input int pe, input int a, input logic [15:0] d);
      @(negedge clk);
      host_we = 1'b1; host_to_data = to_data; host_pe = pe[1:0];
      host_addr = a[3:0]; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic load_prog(input logic [15:0] words [16]);
      for (int a = 0; a < 16; a++) host_write(1'b0, 0, a, words[a]);
   endtask

   task automatic run_wait();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int k = 0; k < 200 && m_ph != 3; k++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic scan(input string req);
      cur_req = req;
      for (int p = 0; p < 4; p++)
         for (int a = 0; a < 16; a++) begin
            @(negedge clk); host_pe = p[1:0]; host_addr = a[3:0];
         end
      @(negedge clk);
   endtask

   initial begin
      logic [15:0] prog [16];

      repeat (3) @(negedge clk);
      #2;
      check("R1", {15'd0, done}, 16'd0);
      check("R1", host_rdata, 16'd0);
      rst_n = 1'b1;
      scan("R1");

      // data fill, R8
      cur_req = "R8";
      for (int p = 0; p < 4; p++)
         for (int a = 0; a < 8; a++)
            host_write(1'b1, p, a, 16'((p * 16'h1234 + a * 16'h0F0F) ^ 16'hA5A5));
      host_write(1'b1, 3, 0, 16'hFFFF);
      host_write(1'b1, 3, 1, 16'h0003);
      scan("R8");

      // R3 / R4: arithmetic with wrap, stores
      for (int a = 0; a < 16; a++) prog[a] = ins(7, 0);
      prog[0] = ins(1, 0); prog[1] = ins(3, 1); prog[2] = ins(2, 2);
      prog[3] = ins(4, 3); prog[4] = ins(2, 4); prog[5] = ins(4, 2);
      prog[6] = ins(2, 12); prog[7] = ins(7, 0);
      load_prog(prog);
      cur_req = "R3";
      run_wait();
      scan("R4");

      // R5 / R6: masking and ring exchange
      for (int a = 0; a < 16; a++) prog[a] = ins(7, 0);
      prog[0] = ins(5, 5);  prog[1] = ins(1, 5);  prog[2] = ins(2, 6);
      prog[3] = ins(5, 15); prog[4] = ins(6, 0);  prog[5] = ins(2, 7);
      prog[6] = ins(5, 10); prog[7] = ins(6, 0);  prog[8] = ins(2, 8);
      prog[9] = ins(7, 0);
      load_prog(prog);
      cur_req = "R5";
      run_wait();
      scan("R6");

      // R7 / R9: no-op codes, mask restored, accumulators kept
      for (int a = 0; a < 16; a++) prog[a] = ins(7, 0);
      prog[0] = ins(2, 9);  prog[1] = ins(5, 0);  prog[2] = ins(1, 0);
      prog[3] = ins(3, 1);  prog[4] = ins(2, 10); prog[5] = ins(6, 0);
      prog[6] = ins(5, 15); prog[7] = ins(2, 11); prog[8] = ins(8, 3);
      prog[9] = ins(15, 1); prog[10] = ins(12, 0); prog[11] = ins(0, 0);
      prog[12] = ins(2, 12); prog[13] = ins(7, 0);
      load_prog(prog);
      cur_req = "R9";
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      // R8: writes during the run must be ignored
      host_we = 1'b1; host_to_data = 1'b1; host_pe = 2'd0;
      host_addr = 4'd15; host_wdata = 16'hDEAD;
      @(negedge clk);
      host_to_data = 1'b0; host_addr = 4'd3; host_wdata = ins(7, 0);
      @(negedge clk);
      host_we = 1'b0;
      for (int k = 0; k < 200 && m_ph != 3; k++) @(negedge clk);
      repeat (3) @(negedge clk);
      scan("R7");

      // rerun same program: the ignored program write must not shorten it
      cur_req = "R8";
      run_wait();
      scan("R8");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule